// File: doc/BRIEF.md
# Active Pullup Timing Controller

This block decides, for each rising edge of an open-drain single-wire bus, whether a pullup transistor should briefly help the passive resistor lift the line. An edge begins when the local or remote pulldown releases the line. From that clock on, a window of a fixed number of cycles is open. If an external comparator reports that the line has reached the mid-level threshold inside that window, the drive enable turns on. It stays on until the window closes, and then the resistor alone holds the line.

Software settings select whether the active pullup is used at all, whether a strong pullup should keep the transistor on after the window, and which of two window lengths (standard or high speed) applies. A flag from the bus sequencer marks edges that come from a presence pulse or from recovery after a short. Such edges never get the active drive. A strong pullup hold lasts until an explicit release input arrives. The release also produces a one-cycle done pulse, which the surrounding logic uses to clear its strong pullup setting. The comparator and the analog slew shaping lie outside the block.

Top module: `apu_ctrl`

## Requirements
- R1: When `cfg_apu_en` is 0 at the start of an edge, `drv_on` stays 0 for that whole edge.
- R2: While `pull_low` is 1, `drv_on` is 0 in the same cycle with no clock delay. An edge starts at the first clock edge that samples `pull_low` at 0 after it was 1. This is start edge 0.
- R3: With the active pullup allowed, `drv_on` becomes 1 right after the first of clock edges 1 to W-1 that samples `lvl_mid` at 1. It then stays 1 even if `lvl_mid` falls.
- R4: The window length W is `STD_WIN` when `cfg_fast` is 0 at start edge 0 and `FAST_WIN` when it is 1. Without a strong pullup hold, `drv_on` returns to 0 after clock edge W. A drive turned on at edge k is therefore high for W-k cycles.
- R5: When `edge_noapu` is 1 at start edge 0, the edge is a presence or short-recovery edge and `drv_on` stays 0 for that edge.
- R6: If `lvl_mid` is not seen at 1 on any of edges 1 to W-1, `drv_on` stays 0 for that edge, even if `lvl_mid` rises later.
- R7: If `cfg_spu_en` was 1 at start edge 0 and the drive is on when the window closes, `drv_on` stays 1 until a clock edge samples `spu_release` at 1. After that edge `drv_on` is 0 and `spu_done` is 1 for exactly one cycle.
- R8: A new pulldown during the drive or the hold clears `drv_on` at once. It produces no `spu_done` pulse, and the next release of the line starts a fresh edge.
- R9: The configuration inputs are sampled only at start edge 0. Changing them later does not alter the current edge.
- R10: After reset, `drv_on` and `spu_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_apu_en | input | 1 | Active pullup allowed |
| cfg_spu_en | input | 1 | Strong pullup requested |
| cfg_fast | input | 1 | High-speed window select |
| pull_low | input | 1 | A pulldown is active on the line |
| lvl_mid | input | 1 | Comparator: line above mid-level threshold |
| edge_noapu | input | 1 | Edge is a presence pulse or short recovery |
| spu_release | input | 1 | Ends a strong pullup hold |
| drv_on | output | 1 | Active pullup transistor enable |
| spu_done | output | 1 | One-cycle pulse when a hold ends |

## Verification
The bench targets the timing of the window boundaries:
- A threshold crossing on the last legal edge must give exactly one cycle of drive.
- A crossing on edge W must give none. A design with an off-by-one window would show one drive cycle too many or too few here.

Mode changes made in the middle of an edge must be ignored. A design that reads the speed or enable bits live would cut the drive short or stretch it.

A pulldown arriving during the drive or during the hold must drop the output combinationally and must not emit the done pulse. A design that uses only a registered output would leave the transistor fighting the pulldown for one cycle.

Presence and short-recovery edges, and edges with the feature off, must never drive.

// File: rtl/apu_ctrl.sv
module apu_ctrl #(
  parameter int STD_WIN  = 48,
  parameter int FAST_WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_apu_en,
  input  logic cfg_spu_en,
  input  logic cfg_fast,
  input  logic pull_low,
  input  logic lvl_mid,
  input  logic edge_noapu,
  input  logic spu_release,
  output logic drv_on,
  output logic spu_done
);
  localparam int MAXW = (STD_WIN > FAST_WIN) ? STD_WIN : FAST_WIN;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] STD_LIM  = CW'(STD_WIN - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_WIN - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_RISE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          drv_q, done_q;
  logic          ok_l, spu_l, fast_l;
  logic [CW-1:0] lim;

  assign lim      = fast_l ? FAST_LIM : STD_LIM;
  assign drv_on   = drv_q & ~pull_low;
  assign spu_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
      ok_l   <= 1'b0;
      spu_l  <= 1'b0;
      fast_l <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pull_low) begin
        st    <= S_LOW;
        drv_q <= 1'b0;
      end else begin
        case (st)
          S_LOW: begin
            st     <= S_RISE;
            cnt    <= '0;
            ok_l   <= cfg_apu_en & ~edge_noapu;
            spu_l  <= cfg_spu_en;
            fast_l <= cfg_fast;
          end
          S_RISE: begin
            if (cnt == lim) begin
              drv_q <= drv_q & spu_l;
              st    <= (drv_q & spu_l) ? S_HOLD : S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
              if (ok_l & lvl_mid) drv_q <= 1'b1;
            end
          end
          S_HOLD: begin
            if (spu_release) begin
              drv_q  <= 1'b0;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/apu_ctrl_chk.sv
module apu_ctrl_chk #(
  parameter int STD_WIN  = 48,
  parameter int FAST_WIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_apu_en,
  input logic cfg_spu_en,
  input logic cfg_fast,
  input logic pull_low,
  input logic lvl_mid,
  input logic edge_noapu,
  input logic spu_release,
  input logic drv_on,
  input logic spu_done,
  input logic hold_now
);
  localparam int MAXW = (STD_WIN > FAST_WIN) ? STD_WIN : FAST_WIN;

  logic prev_low, started, c_block;
  int   c_w, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0;
      started  <= 1'b0;
      c_block  <= 1'b0;
      c_w      <= STD_WIN;
      run      <= 0;
    end else begin
      prev_low <= pull_low;
      if (prev_low && !pull_low) begin
        started <= 1'b1;
        c_block <= !cfg_apu_en || edge_noapu;
        c_w     <= cfg_fast ? FAST_WIN : STD_WIN;
        run     <= 1;
      end else if (started && run <= MAXW) begin
        run <= run + 1;
      end
    end
  end

  a_r2_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> !drv_on);

  // R1 and R5
  a_r1_blocked_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (started && c_block) |-> !drv_on);

  a_r3_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_on) |-> $past(lvl_mid));

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_on && !hold_now) |-> (run <= c_w));

  a_r7_hold_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_now && !pull_low) |-> drv_on);

  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    spu_done |-> ($past(spu_release) && $past(hold_now) && !drv_on));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    spu_done |=> !spu_done);

  initial a_r4_params: assert (STD_WIN >= 2 && FAST_WIN >= 2);
endmodule

bind apu_ctrl apu_ctrl_chk #(.STD_WIN(STD_WIN), .FAST_WIN(FAST_WIN)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_apu_en(cfg_apu_en), .cfg_spu_en(cfg_spu_en),
  .cfg_fast(cfg_fast), .pull_low(pull_low), .lvl_mid(lvl_mid),
  .edge_noapu(edge_noapu), .spu_release(spu_release), .drv_on(drv_on),
  .spu_done(spu_done), .hold_now(st == S_HOLD)
);

// File: tb/apu_ctrl_test.sv
module apu_ctrl_test;
  localparam int SW = 12;
  localparam int FW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_apu_en = 0, cfg_spu_en = 0, cfg_fast = 0;
  logic pull_low = 0, lvl_mid = 0, edge_noapu = 0, spu_release = 0;
  logic drv_on, spu_done;

  apu_ctrl #(.STD_WIN(SW), .FAST_WIN(FW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_apu_en(cfg_apu_en), .cfg_spu_en(cfg_spu_en),
    .cfg_fast(cfg_fast), .pull_low(pull_low), .lvl_mid(lvl_mid),
    .edge_noapu(edge_noapu), .spu_release(spu_release),
    .drv_on(drv_on), .spu_done(spu_done)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R10";
  int on_cnt = 0, done_cnt = 0;

  task automatic check(string t, logic got, logic exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic check_int(string t, int got, int exp, string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, got, exp);
    end
  endtask

  // reference model
  bit m_low = 0, m_rise = 0, m_hold = 0, m_on = 0, m_ok = 0, m_spu = 0, m_done = 0;
  int m_age = 0, m_w = SW;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_low = 0; m_rise = 0; m_hold = 0; m_on = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (pull_low) begin
        m_low = 1; m_rise = 0; m_hold = 0; m_on = 0;
      end else if (m_low) begin
        m_low = 0; m_rise = 1; m_age = 0;
        m_ok = cfg_apu_en && !edge_noapu;
        m_spu = cfg_spu_en;
        m_w = cfg_fast ? FW : SW;
      end else if (m_rise) begin
        m_age++;
        if (m_age == m_w) begin
          m_rise = 0;
          m_hold = m_on && m_spu;
          m_on = m_hold;
        end else if (m_ok && lvl_mid) begin
          m_on = 1;
        end
      end else if (m_hold && spu_release) begin
        m_hold = 0; m_on = 0; m_done = 1;
      end
    end
    #5;
    if (rst_n) begin
      check(tag, drv_on, m_on && !pull_low, "drv_on vs model");
      check(tag, spu_done, m_done, "spu_done vs model");
      if (drv_on) on_cnt++;
      if (spu_done) done_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // pulldown for 3 cycles, release, threshold at edge k, then wait
  task automatic edge_run(int k, int tail);
    on_cnt = 0; done_cnt = 0;
    pull_low = 1; lvl_mid = 0;
    cyc(3);
    pull_low = 0;
    if (k > 0) begin
      cyc(k);
      lvl_mid = 1;
    end
    cyc(tail);
    lvl_mid = 0;
  endtask

  bit finished = 0;
  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    #5;
    tag = "R10";
    check(tag, drv_on, 1'b0, "drv_on after reset");
    check(tag, spu_done, 1'b0, "spu_done after reset");
    @(negedge clk); rst_n = 1;
    cyc(2);

    tag = "R3"; cfg_apu_en = 1;
    edge_run(2, 16);
    check_int("R3", on_cnt, SW - 2, "drive cycles, standard, edge 2");

    tag = "R4"; cfg_fast = 1;
    edge_run(2, 8);
    check_int("R4", on_cnt, FW - 2, "drive cycles, fast, edge 2");
    edge_run(FW - 1, 8);
    check_int("R4", on_cnt, 1, "crossing on last legal edge");
    cfg_fast = 0;

    tag = "R6";
    edge_run(SW, 6);
    check_int("R6", on_cnt, 0, "crossing on edge W");

    tag = "R1"; cfg_apu_en = 0;
    edge_run(1, 16);
    check_int("R1", on_cnt, 0, "drive with feature off");
    cfg_apu_en = 1;

    tag = "R5"; edge_noapu = 1;
    pull_low = 1; cyc(3); pull_low = 0; cyc(1); edge_noapu = 0;
    lvl_mid = 1; cyc(16); lvl_mid = 0;
    check_int("R5", on_cnt, 0, "drive on presence edge");

    tag = "R9"; on_cnt = 0;
    pull_low = 1; cyc(3); pull_low = 0; cyc(1);
    cfg_fast = 1; cfg_apu_en = 0;
    cyc(1); lvl_mid = 1; cyc(16); lvl_mid = 0;
    check_int("R9", on_cnt, SW - 2, "mid-edge config change ignored");
    cfg_fast = 0; cfg_apu_en = 1;

    tag = "R7"; cfg_spu_en = 1;
    edge_run(2, 20);
    check("R7", drv_on, 1'b1, "hold after window");
    spu_release = 1; cyc(1); spu_release = 0; cyc(3);
    check("R7", drv_on, 1'b0, "drive after release");
    check_int("R7", done_cnt, 1, "done pulses");
    check_int("R7", on_cnt, 20, "drive cycles until release");

    tag = "R8";
    edge_run(2, 20);
    pull_low = 1; #1;
    check("R8", drv_on, 1'b0, "drive during new pulldown in hold");
    cyc(2); spu_release = 1; cyc(1); spu_release = 0;
    check_int("R8", done_cnt, 0, "done pulse after interrupted hold");
    pull_low = 0; cyc(2); lvl_mid = 1; cyc(20); lvl_mid = 0;
    check("R8", drv_on, 1'b1, "fresh edge drives and holds");
    spu_release = 1; cyc(1); spu_release = 0; cyc(2);
    cfg_spu_en = 0;

    tag = "R2";
    edge_run(1, 4);
    pull_low = 1; #1;
    check("R2", drv_on, 1'b0, "drive blocked same cycle");
    cyc(3);
    check("R2", drv_on, 1'b0, "drive during pulldown");
    pull_low = 0; cyc(20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule